// File: doc/BRIEF.md
# Synchronous Serial Port Register Front-End

This block is the software-facing half of a synchronous serial master. A simple register bus accesses six word-aligned registers: two control words, a data port, a status word, a clock prescale value and an interrupt status word that doubles as a clear strobe on write. Accesses can be bytes or halfwords. Two eight-frame FIFOs sit behind the data port. Writes fill the transmit queue and reads drain the receive queue. A frame-sequencing state machine passes each queued word to a separate serial shift engine and stores each word the engine returns.

The sequencer has four states. In `ST_OFF` the port is disabled and the engine is held idle. In `ST_IDLE` the port is enabled and waits for transmit data. `ST_LAUNCH` lasts one cycle: it pops the transmit head and pulses the engine start. In `ST_SHIFT` a frame is in flight and the sequencer waits for the engine's completion. The transitions are:

- *enable*: `ST_OFF` to `ST_IDLE`.
- *fetch*: `ST_IDLE` to `ST_LAUNCH`, when the transmit FIFO is not empty.
- *launch*: `ST_LAUNCH` to `ST_SHIFT`.
- *complete*: `ST_SHIFT` to `ST_IDLE`, on engine done.
- *disable*: any enabled state to `ST_OFF`, when the port enable is clear.

Frame size, clock mode, rate divider, prescale, loopback and slave options are passed to the engine unchanged. Chip select is handled outside the block.

Top module: `ssp_regfront`

Register map, by byte offset:

| Offset | Register | Write | Read |
|---|---|---|---|
| 0x00 | frame control | see R2 | see R2 |
| 0x04 | port control | see R10 | see R10 |
| 0x08 | data port | push transmit FIFO (R3) | pop receive FIFO (R5) |
| 0x0C | status | ignored | see R9 |
| 0x10 | prescale | see R10 | see R10 |
| 0x14 | interrupt | clears overrun (R6) | see R7 |

## Requirements
- R1: After reset, the status register reads 0x0003 (transmit empty and transmit not full), every control and prescale register reads 0, all interrupt outputs are low and `eng_halt` is high.
- R2: An access is decoded only when `bus_addr[1:0]` is 0; a misaligned write has no effect. The frame control register at 0x00 reads back as {rate[15:8], mode[7:6], 2'b00, size[3:0]}. A byte write (`bus_half`=0) updates only bits [7:0]. A halfword write also updates the rate.
- R3: A write to the data port at 0x08 pushes (written value AND mask) into the 8-entry transmit FIFO. The mask keeps the low size+1 bits, and a byte write supplies zero in bits [15:8]. A write while the FIFO holds 8 words is dropped.
- R4: While enabled and holding transmit data, the block raises `eng_start` for exactly one cycle with the oldest queued word on `eng_word`. There is no further start until `eng_done` completes that frame.
- R5: `eng_done` during a frame stores `eng_rx_word` masked to the frame size. A read of 0x08 returns and removes the oldest stored word. A read while the receive FIFO is empty returns 0 and changes nothing.
- R6: A completion while the receive FIFO holds 8 words discards the frame and sets a sticky overrun flag. Any write to 0x14 clears the flag. `irq_ovr` is the flag gated by port-control bit 2.
- R7: `irq_rx` is high when the receive FIFO holds 4 or more words and port-control bit 0 is set. `irq_tx` is high when the transmit FIFO holds 4 or fewer words and bit 1 is set. `irq_any` is the OR of the three interrupts. Register 0x14 reads {overrun[2], transmit[1], receive[0]} of the gated interrupts.
- R8: Writing port-control bit 4 from 1 to 0 empties both FIFOs. The engine is held idle (`eng_halt` high), and a completion that arrives afterwards is not stored.
- R9: Status bits are: [0] transmit empty, [1] transmit not full, [2] receive not empty, [3] receive full, [4] busy. Busy is high when the port is enabled and either a frame is in flight or transmit data is queued.
- R10: The configuration outputs mirror the registers: `cfg_size`, `cfg_mode` and `cfg_rate` from 0x00. From port control at 0x04: loopback from bit 3, slave from bit 5, slave output disable from bit 6. Bits [6:0] of 0x04 read back as written. The prescale at 0x10 stores bits [7:1] of the written value with bit 0 forced to 0.
- R11: While the port is disabled, the transmit FIFO accepts data and no frame is started. When the port is enabled, the queued words go out in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| bus_sel | input | 1 | register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_half | input | 1 | 1 = halfword, 0 = byte |
| bus_addr | input | 5 | byte offset |
| bus_wdata | input | 16 | write data |
| bus_rdata | output | 16 | read data, 0 when not reading |
| eng_start | output | 1 | one-cycle frame start to shift engine |
| eng_word | output | 16 | transmit word for the started frame |
| eng_done | input | 1 | frame completed by shift engine |
| eng_rx_word | input | 16 | word received by shift engine |
| eng_halt | output | 1 | hold shift engine idle |
| cfg_size | output | 4 | bits per frame minus one |
| cfg_mode | output | 2 | clock polarity and phase |
| cfg_rate | output | 8 | serial clock rate divider |
| cfg_prescale | output | 8 | clock prescale (even) |
| cfg_loopback | output | 1 | internal loopback request |
| cfg_slave | output | 1 | slave mode select |
| cfg_slave_od | output | 1 | slave output disable |
| irq_rx | output | 1 | receive level interrupt |
| irq_tx | output | 1 | transmit level interrupt |
| irq_ovr | output | 1 | receive overrun interrupt |
| irq_any | output | 1 | OR of the three interrupts |

## Verification
The read pointer and the occupancy count are separate state. If either is wrong, the error shows at the data port: a read returns a word other than the oldest unread one, and the receive-full and receive-not-empty status bits disagree with the number of frames sent. The sequencer state is visible through `eng_start` and the busy bit. A sequencer that sticks in `ST_SHIFT` or starts twice changes the count of engine starts within one frame time. A lost flush shows on the status register in the cycle after the disabling write completes. A non-sticky overrun flag drops `irq_ovr` before the clearing write.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 5;

    localparam logic [2:0] IDX_CTRL0 = 3'd0;
    localparam logic [2:0] IDX_CTRL1 = 3'd1;
    localparam logic [2:0] IDX_DATA  = 3'd2;
    localparam logic [2:0] IDX_STAT  = 3'd3;
    localparam logic [2:0] IDX_PRESC = 3'd4;
    localparam logic [2:0] IDX_IRQ   = 3'd5;

    localparam int C1_EN_BIT = 4;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_IDLE,
        ST_LAUNCH,
        ST_SHIFT
    } port_state_e;

    typedef struct packed {
        logic [7:0] rate;
        logic [1:0] mode;
        logic [3:0] size;
    } frame_ctrl_t;

    typedef struct packed {
        logic slave_od;
        logic slave;
        logic enable;
        logic loopback;
        logic ovr_ie;
        logic tx_ie;
        logic rx_ie;
    } port_ctrl_t;

    // keep the low (size+1) bits of a word
    function automatic logic [WORD_W-1:0] size_mask(input logic [3:0] size);
        return {WORD_W{1'b1}} >> (4'd15 - size);
    endfunction

endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !do_push)
                count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !(!rst_n || flush))
            store[wr_ptr] <= push_data;
    end

endmodule

// File: rtl/ssp_regs.sv
module ssp_regs
    import ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_half,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output frame_ctrl_t       fctrl,
    output port_ctrl_t        pctrl,
    output logic [7:0]        prescale,
    output logic              tx_push,
    output logic [WORD_W-1:0] tx_word,
    output logic              rx_pop,
    output logic              flush,
    output logic              ovr_clr,
    input  logic [WORD_W-1:0] rx_head,
    input  logic              rx_empty,
    input  logic              rx_full,
    input  logic              tx_empty,
    input  logic              tx_full,
    input  logic              busy,
    input  logic [2:0]        irq_vec
);
    logic              hit;
    logic [2:0]        idx;
    logic              wr_hit, rd_hit;
    logic [WORD_W-1:0] lane;
    logic [WORD_W-1:0] rd_word;

    assign hit    = bus_sel && (bus_addr[1:0] == 2'b00);
    assign idx    = bus_addr[4:2];
    assign wr_hit = hit && bus_wr;
    assign rd_hit = hit && !bus_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fctrl    <= '0;
            pctrl    <= '0;
            prescale <= '0;
        end else if (wr_hit) begin
            case (idx)
                IDX_CTRL0: begin
                    fctrl.size <= bus_wdata[3:0];
                    fctrl.mode <= bus_wdata[7:6];
                    if (bus_half)
                        fctrl.rate <= bus_wdata[15:8];
                end
                IDX_CTRL1: pctrl    <= port_ctrl_t'(bus_wdata[6:0]);
                IDX_PRESC: prescale <= {bus_wdata[7:1], 1'b0};
                default:   ;
            endcase
        end
    end

    assign lane    = bus_half ? bus_wdata : {8'h00, bus_wdata[7:0]};
    assign tx_word = lane & size_mask(fctrl.size);
    assign tx_push = wr_hit && (idx == IDX_DATA);
    assign rx_pop  = rd_hit && (idx == IDX_DATA);
    assign ovr_clr = wr_hit && (idx == IDX_IRQ);
    assign flush   = wr_hit && (idx == IDX_CTRL1) && pctrl.enable
                     && !bus_wdata[C1_EN_BIT];

    always_comb begin
        rd_word = '0;
        case (idx)
            IDX_CTRL0: rd_word = {fctrl.rate, fctrl.mode, 2'b00, fctrl.size};
            IDX_CTRL1: rd_word = {9'd0, pctrl};
            IDX_DATA:  rd_word = rx_empty ? '0 : rx_head;
            IDX_STAT:  rd_word = {11'd0, busy, rx_full, !rx_empty, !tx_full, tx_empty};
            IDX_PRESC: rd_word = {8'd0, prescale};
            IDX_IRQ:   rd_word = {13'd0, irq_vec};
            default:   rd_word = '0;
        endcase
    end

    assign bus_rdata = !rd_hit ? '0 : (bus_half ? rd_word : {8'h00, rd_word[7:0]});

endmodule

// File: rtl/ssp_port_fsm.sv
module ssp_port_fsm
    import ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic [3:0]        size,
    input  logic              tx_empty,
    input  logic [WORD_W-1:0] tx_head,
    input  logic              rx_full,
    input  logic              eng_done,
    input  logic [WORD_W-1:0] eng_rx_word,
    input  logic              ovr_clr,
    output logic              eng_start,
    output logic [WORD_W-1:0] eng_word,
    output logic              eng_halt,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word,
    output logic              in_flight,
    output logic              ovr_flag
);
    port_state_e state, nxt;
    logic accept, ovr_set;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_OFF;
        else
            state <= nxt;
    end

    // transitions: enable, fetch, launch, complete, disable
    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:    if (port_en) nxt = ST_IDLE;
            ST_IDLE:   if (!port_en) nxt = ST_OFF;
                       else if (!tx_empty) nxt = ST_LAUNCH;
            ST_LAUNCH: if (!port_en) nxt = ST_OFF;
                       else nxt = ST_SHIFT;
            ST_SHIFT:  if (!port_en) nxt = ST_OFF;
                       else if (eng_done) nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        eng_start = 1'b0;
        eng_halt  = 1'b0;
        in_flight = 1'b0;
        accept    = 1'b0;
        unique case (state)
            ST_OFF:    eng_halt = 1'b1;
            ST_IDLE:   ;
            ST_LAUNCH: begin
                eng_start = port_en;
                in_flight = 1'b1;
            end
            ST_SHIFT: begin
                in_flight = 1'b1;
                accept    = port_en && eng_done;
            end
        endcase
    end

    assign eng_word = tx_head;
    assign tx_pop   = eng_start;
    assign rx_word  = eng_rx_word & size_mask(size);
    assign rx_push  = accept && !rx_full;
    assign ovr_set  = accept && rx_full;

    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr_flag <= 1'b0;
        else if (ovr_set)
            ovr_flag <= 1'b1;
        else if (ovr_clr)
            ovr_flag <= 1'b0;
    end

endmodule

// File: rtl/ssp_regfront.sv
module ssp_regfront
    import ssp_pkg::*;
#(
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_half,
    input  logic [4:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              eng_start,
    output logic [15:0]       eng_word,
    input  logic              eng_done,
    input  logic [15:0]       eng_rx_word,
    output logic              eng_halt,
    output logic [3:0]        cfg_size,
    output logic [1:0]        cfg_mode,
    output logic [7:0]        cfg_rate,
    output logic [7:0]        cfg_prescale,
    output logic              cfg_loopback,
    output logic              cfg_slave,
    output logic              cfg_slave_od,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              irq_ovr,
    output logic              irq_any
);
    localparam int CNT_W = $clog2(FIFO_DEPTH+1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(FIFO_DEPTH / 2);

    frame_ctrl_t       fctrl;
    port_ctrl_t        pctrl;
    logic [7:0]        prescale;
    logic              tx_push, rx_pop, tx_pop, rx_push, flush, ovr_clr;
    logic [WORD_W-1:0] tx_word, tx_head, rx_word, rx_head;
    logic [CNT_W-1:0]  tx_count, rx_count;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic              in_flight, ovr_flag, busy, port_en;
    logic [2:0]        irq_vec;

    assign port_en = pctrl.enable;

    ssp_regs i_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_half(bus_half),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fctrl(fctrl), .pctrl(pctrl), .prescale(prescale),
        .tx_push(tx_push), .tx_word(tx_word), .rx_pop(rx_pop),
        .flush(flush), .ovr_clr(ovr_clr),
        .rx_head(rx_head), .rx_empty(rx_empty), .rx_full(rx_full),
        .tx_empty(tx_empty), .tx_full(tx_full), .busy(busy), .irq_vec(irq_vec)
    );

    ssp_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) i_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(tx_push), .push_data(tx_word), .pop(tx_pop),
        .head(tx_head), .count(tx_count), .empty(tx_empty), .full(tx_full)
    );

    ssp_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) i_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(rx_push), .push_data(rx_word), .pop(rx_pop),
        .head(rx_head), .count(rx_count), .empty(rx_empty), .full(rx_full)
    );

    ssp_port_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .size(fctrl.size),
        .tx_empty(tx_empty), .tx_head(tx_head), .rx_full(rx_full),
        .eng_done(eng_done), .eng_rx_word(eng_rx_word), .ovr_clr(ovr_clr),
        .eng_start(eng_start), .eng_word(eng_word), .eng_halt(eng_halt),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
        .in_flight(in_flight), .ovr_flag(ovr_flag)
    );

    assign busy    = port_en && (in_flight || !tx_empty);
    assign irq_rx  = pctrl.rx_ie  && (rx_count >= HALF);
    assign irq_tx  = pctrl.tx_ie  && (tx_count <= HALF);
    assign irq_ovr = pctrl.ovr_ie && ovr_flag;
    assign irq_vec = {irq_ovr, irq_tx, irq_rx};
    assign irq_any = |irq_vec;

    assign cfg_size     = fctrl.size;
    assign cfg_mode     = fctrl.mode;
    assign cfg_rate     = fctrl.rate;
    assign cfg_prescale = prescale;
    assign cfg_loopback = pctrl.loopback;
    assign cfg_slave    = pctrl.slave;
    assign cfg_slave_od = pctrl.slave_od;

endmodule

// File: rtl/ssp_regfront_chk.sv
module ssp_regfront_chk #(
    parameter int DEPTH = 8
) (
    input logic clk,
    input logic rst_n,
    input logic eng_start,
    input logic eng_halt,
    input logic ovr_flag,
    input logic ovr_clr,
    input logic port_en,
    input logic [$clog2(DEPTH+1)-1:0] tx_count,
    input logic [$clog2(DEPTH+1)-1:0] rx_count,
    input logic tx_empty,
    input logic rx_empty
);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DEPTH);

    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    assert_start_has_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !tx_empty);

    assert_halt_no_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        eng_halt |-> !eng_start);

    assert_ovr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clr) |=> ovr_flag);

    assert_rx_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= LIMIT);

    assert_tx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= LIMIT);

    assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(port_en) |-> (tx_empty && rx_empty));

endmodule

bind ssp_regfront ssp_regfront_chk #(.DEPTH(FIFO_DEPTH)) i_chk (
    .clk(clk), .rst_n(rst_n), .eng_start(eng_start), .eng_halt(eng_halt),
    .ovr_flag(ovr_flag), .ovr_clr(ovr_clr), .port_en(port_en),
    .tx_count(tx_count), .rx_count(rx_count),
    .tx_empty(tx_empty), .rx_empty(rx_empty)
);

// File: tb/test_ssp_regfront.sv
module test_ssp_regfront;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] XORV = 16'hA5C3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 0, bus_wr = 0, bus_half = 0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic eng_start, eng_halt;
    logic [15:0] eng_word;
    logic eng_done = 1'b0;
    logic [15:0] eng_rx_word = '0;
    logic [3:0] cfg_size;
    logic [1:0] cfg_mode;
    logic [7:0] cfg_rate, cfg_prescale;
    logic cfg_loopback, cfg_slave, cfg_slave_od;
    logic irq_rx, irq_tx, irq_ovr, irq_any;

    int checks = 0;
    int errors = 0;
    int starts = 0;
    logic [15:0] sent [16];
    bit eng_mute = 0;
    int eng_lat = 3;

    always #(CLK_PERIOD/2) clk = ~clk;

    ssp_regfront i_ssp_regfront (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_half(bus_half), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .eng_start(eng_start), .eng_word(eng_word),
        .eng_done(eng_done), .eng_rx_word(eng_rx_word), .eng_halt(eng_halt),
        .cfg_size(cfg_size), .cfg_mode(cfg_mode), .cfg_rate(cfg_rate),
        .cfg_prescale(cfg_prescale), .cfg_loopback(cfg_loopback),
        .cfg_slave(cfg_slave), .cfg_slave_od(cfg_slave_od),
        .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_ovr(irq_ovr), .irq_any(irq_any)
    );

    // shift engine model: replies word ^ XORV after eng_lat cycles
    initial begin
        forever begin
            @(negedge clk);
            eng_done = 1'b0;
            if (eng_start && !eng_mute) begin
                if (starts < 16) sent[starts] = eng_word;
                starts++;
                repeat (eng_lat) @(negedge clk);
                eng_rx_word = eng_word ^ XORV;
                eng_rx_word = sent[(starts-1) % 16] ^ XORV;
                eng_done = 1'b1;
            end else if (eng_start) begin
                starts++;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d, input bit half);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_half = half;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a, input bit half, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a; bus_half = half;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic fresh();
        @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        starts = 0;
        eng_mute = 0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        fresh();
        rd(5'h0C, 1, v); check("R1 status", v, 16'h0003);
        rd(5'h00, 1, v); check("R1 ctrl0", v, 0);
        rd(5'h04, 1, v); check("R1 ctrl1", v, 0);
        rd(5'h10, 1, v); check("R1 prescale", v, 0);
        check("R1 irqs", {irq_rx, irq_tx, irq_ovr, irq_any, eng_halt}, 5'b00001);
    endtask

    task automatic t_config();
        logic [15:0] v;
        fresh();
        wr(5'h00, 16'hFFFF, 1);
        rd(5'h00, 1, v); check("R2 half write", v, 16'hFFCF);
        wr(5'h00, 16'h1207, 0);
        rd(5'h00, 1, v); check("R2 byte write keeps rate", v, 16'hFF07);
        wr(5'h01, 16'h0000, 1);
        rd(5'h00, 1, v); check("R2 misaligned ignored", v, 16'hFF07);
        check("R10 frame cfg", {cfg_rate, cfg_mode, cfg_size}, {8'hFF, 2'b00, 4'h7});
        wr(5'h10, 16'h0033, 1);
        rd(5'h10, 1, v); check("R10 prescale even", v, 16'h0032);
        check("R10 prescale out", cfg_prescale, 8'h32);
        wr(5'h04, 16'h0068, 1);
        rd(5'h04, 1, v); check("R10 ctrl1 readback", v, 16'h0068);
        check("R10 mode bits", {cfg_slave_od, cfg_slave, cfg_loopback}, 3'b111);
    endtask

    task automatic t_basic();
        logic [15:0] v;
        fresh();
        wr(5'h00, 16'h0007, 1);
        wr(5'h04, 16'h0010, 1);
        wr(5'h08, 16'h1234, 1);
        repeat (12) @(negedge clk);
        check("R4 one start", starts, 1);
        check("R3 masked word", sent[0], 16'h0034);
        rd(5'h0C, 1, v); check("R5 rx not empty", v, 16'h0007);
        rd(5'h08, 1, v); check("R5 rx word", v, 16'h00F7);
        rd(5'h08, 1, v); check("R5 empty read zero", v, 16'h0000);
        rd(5'h0C, 1, v); check("R5 empty status", v, 16'h0003);
    endtask

    task automatic t_stream();
        logic [15:0] v;
        fresh();
        wr(5'h00, 16'h000F, 1);
        wr(5'h04, 16'h0011, 1);
        for (int i = 0; i < 3; i++) wr(5'h08, 16'h1000 + 16'(i * 16'h0111), 1);
        repeat (40) @(negedge clk);
        check("R4 three starts", starts, 3);
        check("R7 rx irq below half", irq_rx, 0);
        wr(5'h08, 16'hBEEF, 1);
        repeat (15) @(negedge clk);
        check("R7 rx irq at half", {irq_rx, irq_any}, 2'b11);
        for (int i = 0; i < 3; i++) begin
            rd(5'h08, 1, v);
            check("R5 order", v, (16'h1000 + 16'(i * 16'h0111)) ^ XORV);
        end
        check("R7 rx irq drops", irq_rx, 0);
        rd(5'h08, 0, v); check("R5 byte read", v, 16'h00EF ^ 16'h00C3);
    endtask

    task automatic t_tx_level_flush();
        logic [15:0] v;
        fresh();
        wr(5'h00, 16'h000F, 1);
        eng_mute = 1;
        wr(5'h04, 16'h0012, 1);
        check("R7 tx irq empty", irq_tx, 1);
        for (int i = 0; i < 5; i++) wr(5'h08, 16'h0100 + 16'(i), 1);
        repeat (3) @(negedge clk);
        check("R4 single start while stalled", starts, 1);
        check("R7 tx irq at four", irq_tx, 1);
        wr(5'h08, 16'h0200, 1);
        check("R7 tx irq at five", irq_tx, 0);
        rd(5'h0C, 1, v); check("R9 busy queued", v, 16'h0012);
        wr(5'h04, 16'h0002, 1);
        rd(5'h0C, 1, v); check("R8 flush status", v, 16'h0003);
        check("R8 halt", eng_halt, 1);
        eng_mute = 0;
        wr(5'h04, 16'h0012, 1);
        wr(5'h08, 16'h4444, 1);
        repeat (2) @(negedge clk);
        wr(5'h04, 16'h0002, 1);
        repeat (10) @(negedge clk);
        rd(5'h0C, 1, v); check("R8 late completion dropped", v, 16'h0003);
    endtask

    task automatic t_prefill_overrun();
        logic [15:0] v;
        fresh();
        wr(5'h00, 16'h0007, 1);
        for (int i = 0; i < 9; i++) wr(5'h08, 16'h0010 + 16'(i), 0);
        rd(5'h0C, 1, v); check("R3 tx full drop", v, 16'h0000);
        check("R11 no start disabled", starts, 0);
        wr(5'h04, 16'h0014, 1);
        rd(5'h0C, 1, v); check("R9 busy enabled", v[4], 1'b1);
        repeat (80) @(negedge clk);
        check("R11 eight sent", starts, 8);
        check("R11 last word", sent[7], 16'h0017);
        rd(5'h0C, 1, v); check("R9 rx full idle", v, 16'h000F);
        check("R7 rx irq gated", irq_rx, 0);
        check("R6 no overrun yet", irq_ovr, 0);
        wr(5'h08, 16'h0077, 0);
        repeat (12) @(negedge clk);
        check("R6 overrun irq", irq_ovr, 1);
        rd(5'h14, 1, v); check("R6 irq status", v, 16'h0004);
        repeat (3) @(negedge clk);
        check("R6 sticky", irq_ovr, 1);
        wr(5'h14, 16'h0000, 1);
        check("R6 cleared", irq_ovr, 0);
        for (int i = 0; i < 8; i++) begin
            rd(5'h08, 1, v);
            check("R6 kept frames", v, ((16'h0010 + 16'(i)) ^ XORV) & 16'h00FF);
        end
        rd(5'h0C, 1, v); check("R6 discarded frame", v, 16'h0003);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_config();
        t_basic();
        t_stream();
        t_tx_level_flush();
        t_prefill_overrun();
        finish_run();
    end

endmodule